// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steers a small processor core between its operating modes: full-speed active, sleep, subsleep, subactive on a divided subclock, and standby. It decodes a one-cycle sleep-request strobe against a control-register image. It turns qualified interrupt requests into wake-ups and follows an external reset pin through an oscillator-settling hold. From the current mode it drives the clock-gate enables for the CPU, the peripherals and the real-time counter. It also drives the main-oscillator enable, the subclock divide ratio, an internal reset and a one-cycle wake strobe.

The core enters full speed only after a programmable settling wait. The settling-time code selects 8·2^code cycles of the block clock, counted by a down-counter. The subclock ratio is sampled at the moment of each sleep request. Changes to the select field made while the core sleeps therefore have no effect until the next request, and the core resumes at the ratio it had before.

Top module: `lpm_sequencer`

## Requirements
- R1: In subsleep, `cpu_clk_en`=0, `per_clk_en`=0, `osc_en`=0 and `rtc_clk_en`=1.
- R2: A wake from sleep or subsleep needs at least one `irq_pend` bit whose `irq_en` bit is also 1, together with `irq_gmask`=0. Any other combination leaves the mode unchanged.
- R3: On a qualified interrupt in subsleep, the next mode is subactive (CPU clock on in the next cycle) when `cfg_lowspeed`=1, and the settling wait followed by active when it is 0.
- R4: Active is entered only from the settling wait or from reset hold. The settling wait loads 8<<`cfg_settle` (codes 0..7 give 8..1024 cycles) at entry and lasts exactly that many cycles, with `osc_en`=1 and `cpu_clk_en`=0.
- R5: `clk_shift` is log2 of the subclock divisor: select codes 00, 01 and 10 give 1, 2 and 3, and the reserved code 11 gives 3. It shows this value in subactive, in subsleep and in sleep entered from subactive, and 0 in every other mode.
- R6: The ratio is sampled from `cfg_subdiv` on every `sleep_req` seen in active or subactive, and is held at all other times.
- R7: A `sleep_req` in active or subactive is decoded with this priority. `cfg_standby`=1 gives standby. Otherwise `cfg_direct`=1 gives subactive when `cfg_lowspeed`=1; with `cfg_lowspeed`=0 it gives the settling wait from subactive and no change from active. Otherwise `cfg_lowspeed`=1 gives subsleep and 0 gives sleep. In all other modes the request is ignored.
- R8: In sleep, `cpu_clk_en`=0, `per_clk_en`=1 and `rtc_clk_en`=1, with `osc_en`=1 only if sleep was entered from active. A wake returns to subactive if sleep was entered from subactive, and otherwise goes through the settling wait to active.
- R9: In standby, all enables are 0 except `rtc_clk_en`. Interrupts are ignored, and only the reset pin leaves standby.
- R10: When `res_pin_n`=0 in any mode, reset hold follows in the next cycle with `int_rst`=1 and `osc_en`=1. On entry from another mode the settle count 8<<`cfg_settle` is loaded. The hold releases into active in the first cycle in which the count has elapsed and the pin is high. After `rst_n` the block is in reset hold with the count already elapsed.
- R11: `wake_pulse` is 1 for exactly the first cycle after an interrupt takes the block out of sleep or subsleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sleep_req | input | 1 | One-cycle sleep request strobe |
| cfg_standby | input | 1 | Standby select |
| cfg_direct | input | 1 | Direct mode-switch select |
| cfg_lowspeed | input | 1 | Low-speed-on flag |
| cfg_settle | input | SETTLE_W | Settling-time code |
| cfg_subdiv | input | SEL_W | Subclock divider select |
| irq_pend | input | NUM_IRQ | Pending interrupt requests |
| irq_en | input | NUM_IRQ | Per-source interrupt enables |
| irq_gmask | input | 1 | Global interrupt mask (1 blocks) |
| res_pin_n | input | 1 | External reset pin, active low |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| rtc_clk_en | output | 1 | Real-time counter clock gate enable |
| osc_en | output | 1 | Main oscillator enable |
| clk_shift | output | SEL_W | Subclock divide as log2, 0 for full speed |
| int_rst | output | 1 | Internal reset |
| wake_pulse | output | 1 | One-cycle wake strobe |

## Verification
The decode is driven with each control combination from both active and subactive. This separates the standby, direct, subsleep and sleep branches and the asymmetric no-change case. Wake-ups are attempted with a disabled source, then with an enabled but globally masked source, then with a qualified source, which tells the per-source gate apart from the global mask. The settling and reset-hold intervals are timed to the exact cycle at two different codes, and a select change made during sleep shows whether the ratio is captured at the request or read live.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        M_RSTH     = 3'd0,
        M_ACT      = 3'd1,
        M_SETTLE   = 3'd2,
        M_SLEEP    = 3'd3,
        M_SUBSLEEP = 3'd4,
        M_SUBACT   = 3'd5,
        M_STBY     = 3'd6
    } lp_mode_e;

    typedef struct packed {
        lp_mode_e mode;
        logic     ret_sub;  // sleep was entered from subactive
        logic     wake;     // wake strobe for the current cycle
    } seq_state_t;

endpackage

// File: rtl/lpm_irq_qual.sv
module lpm_irq_qual #(
    parameter int NUM_IRQ = 8
) (
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               irq_gmask,
    output logic               hit_o
);
    logic [NUM_IRQ-1:0] live;

    always_comb begin
        live  = irq_pend & irq_en;
        hit_o = (|live) & ~irq_gmask;
    end
endmodule

// File: rtl/lpm_settle_cnt.sv
module lpm_settle_cnt #(
    parameter int CODE_W   = 3,
    parameter int BASE_LOG = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              zero_o,
    output logic              last_o
);
    localparam int CNT_W = BASE_LOG + (1 << CODE_W);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = ONE << (BASE_LOG + int'(code_i));
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - ONE;
        end
        zero_o = (cnt_q == '0);
        last_o = (cnt_q == ONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: once loaded, the interval runs down one step per cycle
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);

    // R4: every load is a power of two
    p_load_pow2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> $countones(cnt_q) == 1);
endmodule

// File: rtl/lpm_ratio_reg.sv
module lpm_ratio_reg #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [SEL_W-1:0] shift_o
);
    localparam logic [SEL_W-1:0] ONE = SEL_W'(1);

    logic [SEL_W-1:0] shift_q, shift_d;

    always_comb begin
        shift_d = shift_q;
        if (capture_i) begin
            // top code is reserved and saturates to the slowest ratio
            shift_d = (sel_i == '1) ? '1 : sel_i + ONE;
        end
        shift_o = shift_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= ONE;
        else        shift_q <= shift_d;
    end

    p_ratio_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(shift_q));

    p_ratio_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_q != '0);
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int NUM_IRQ  = 8,
    parameter int SETTLE_W = 3,
    parameter int BASE_LOG = 3,
    parameter int SEL_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sleep_req,
    input  logic                cfg_standby,
    input  logic                cfg_direct,
    input  logic                cfg_lowspeed,
    input  logic [SETTLE_W-1:0] cfg_settle,
    input  logic [SEL_W-1:0]    cfg_subdiv,
    input  logic [NUM_IRQ-1:0]  irq_pend,
    input  logic [NUM_IRQ-1:0]  irq_en,
    input  logic                irq_gmask,
    input  logic                res_pin_n,
    output logic                cpu_clk_en,
    output logic                per_clk_en,
    output logic                rtc_clk_en,
    output logic                osc_en,
    output logic [SEL_W-1:0]    clk_shift,
    output logic                int_rst,
    output logic                wake_pulse
);
    seq_state_t       st_q, st_d;
    logic             irq_hit;
    logic             cnt_load, cnt_zero, cnt_last;
    logic             ratio_cap;
    logic [SEL_W-1:0] ratio_shift;
    logic             run_mode;

    lpm_irq_qual #(.NUM_IRQ(NUM_IRQ)) u_irq (
        .irq_pend  (irq_pend),
        .irq_en    (irq_en),
        .irq_gmask (irq_gmask),
        .hit_o     (irq_hit)
    );

    lpm_settle_cnt #(.CODE_W(SETTLE_W), .BASE_LOG(BASE_LOG)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cnt_load),
        .code_i (cfg_settle),
        .zero_o (cnt_zero),
        .last_o (cnt_last)
    );

    lpm_ratio_reg #(.SEL_W(SEL_W)) u_ratio (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (ratio_cap),
        .sel_i     (cfg_subdiv),
        .shift_o   (ratio_shift)
    );

    // next-state process
    always_comb begin
        st_d      = st_q;
        st_d.wake = 1'b0;
        cnt_load  = 1'b0;
        run_mode  = (st_q.mode == M_ACT) || (st_q.mode == M_SUBACT);
        ratio_cap = sleep_req && run_mode;

        if (!res_pin_n) begin
            st_d.mode = M_RSTH;
            cnt_load  = (st_q.mode != M_RSTH);
        end else begin
            unique case (st_q.mode)
                M_RSTH: begin
                    if (cnt_zero) st_d.mode = M_ACT;
                end
                M_ACT, M_SUBACT: begin
                    if (sleep_req) begin
                        st_d.ret_sub = (st_q.mode == M_SUBACT);
                        if (cfg_standby) begin
                            st_d.mode = M_STBY;
                        end else if (cfg_direct) begin
                            if (cfg_lowspeed) begin
                                st_d.mode = M_SUBACT;
                            end else if (st_q.mode == M_SUBACT) begin
                                st_d.mode = M_SETTLE;
                                cnt_load  = 1'b1;
                            end
                        end else if (cfg_lowspeed) begin
                            st_d.mode = M_SUBSLEEP;
                        end else begin
                            st_d.mode = M_SLEEP;
                        end
                    end
                end
                M_SLEEP: begin
                    if (irq_hit) begin
                        st_d.wake = 1'b1;
                        if (st_q.ret_sub) begin
                            st_d.mode = M_SUBACT;
                        end else begin
                            st_d.mode = M_SETTLE;
                            cnt_load  = 1'b1;
                        end
                    end
                end
                M_SUBSLEEP: begin
                    if (irq_hit) begin
                        st_d.wake = 1'b1;
                        if (cfg_lowspeed) begin
                            st_d.mode = M_SUBACT;
                        end else begin
                            st_d.mode = M_SETTLE;
                            cnt_load  = 1'b1;
                        end
                    end
                end
                M_SETTLE: begin
                    if (cnt_last) st_d.mode = M_ACT;
                end
                default: begin
                    st_d.mode = st_q.mode;  // standby: only the pin leaves it
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: M_RSTH, ret_sub: 1'b0, wake: 1'b0};
        else        st_q <= st_d;
    end

    // output decode from the registered mode
    always_comb begin
        cpu_clk_en = (st_q.mode == M_ACT) || (st_q.mode == M_SUBACT);
        per_clk_en = cpu_clk_en || (st_q.mode == M_SLEEP);
        rtc_clk_en = (st_q.mode != M_RSTH);
        osc_en     = (st_q.mode == M_ACT) || (st_q.mode == M_SETTLE) ||
                     (st_q.mode == M_RSTH) ||
                     ((st_q.mode == M_SLEEP) && !st_q.ret_sub);
        clk_shift  = ((st_q.mode == M_SUBACT) || (st_q.mode == M_SUBSLEEP) ||
                      ((st_q.mode == M_SLEEP) && st_q.ret_sub)) ? ratio_shift : '0;
        int_rst    = (st_q.mode == M_RSTH);
        wake_pulse = st_q.wake;
    end

    p_masked_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_SUBSLEEP && res_pin_n && !irq_hit) |=> st_q.mode == M_SUBSLEEP);

    p_wake_lowspeed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_SUBSLEEP && res_pin_n && irq_hit && cfg_lowspeed)
            |=> (cpu_clk_en && wake_pulse && st_q.mode == M_SUBACT));

    p_active_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_SLEEP || st_q.mode == M_SUBSLEEP ||
         st_q.mode == M_SUBACT || st_q.mode == M_STBY) |=> st_q.mode != M_ACT);

    p_standby_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_STBY && res_pin_n) |=> (st_q.mode == M_STBY && !cpu_clk_en));

    p_pin_resets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !res_pin_n |=> (int_rst && osc_en && !cpu_clk_en));

    p_wake_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);
endmodule

// File: tb/lpm_sequencer_test.sv
module lpm_sequencer_test;
    localparam int NI = 8;
    localparam int B_RSTH = 0, B_ACT = 1, B_SET = 2, B_SLP = 3, B_SSLP = 4, B_SUB = 5, B_STBY = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sleep_req = 0, cfg_standby = 0, cfg_direct = 0, cfg_lowspeed = 0;
    logic [2:0] cfg_settle = 0;
    logic [1:0] cfg_subdiv = 0;
    logic [NI-1:0] irq_pend = 0, irq_en = 0;
    logic irq_gmask = 0, res_pin_n = 1;
    logic cpu_clk_en, per_clk_en, rtc_clk_en, osc_en, int_rst, wake_pulse;
    logic [1:0] clk_shift;

    int checks = 0, fails = 0;
    bit started = 0, done = 0;

    lpm_sequencer uut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .cfg_standby(cfg_standby),
        .cfg_direct(cfg_direct), .cfg_lowspeed(cfg_lowspeed), .cfg_settle(cfg_settle),
        .cfg_subdiv(cfg_subdiv), .irq_pend(irq_pend), .irq_en(irq_en), .irq_gmask(irq_gmask),
        .res_pin_n(res_pin_n), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .rtc_clk_en(rtc_clk_en), .osc_en(osc_en), .clk_shift(clk_shift),
        .int_rst(int_rst), .wake_pulse(wake_pulse)
    );

    always #5 clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_mode = B_RSTH, m_cnt = 0, m_shift = 1, m_ret = 0, m_wake = 0;

    always @(posedge clk) begin : model
        int nm, nc, nw;
        bit hit, run;
        started = 1;
        if (!rst_n) begin
            m_mode = B_RSTH; m_cnt = 0; m_shift = 1; m_ret = 0; m_wake = 0;
        end else begin
            hit = ((irq_pend & irq_en) != 0) && !irq_gmask;
            run = (m_mode == B_ACT) || (m_mode == B_SUB);
            nm = m_mode; nw = 0;
            nc = (m_cnt > 0) ? m_cnt - 1 : 0;
            if (sleep_req && run) m_shift = (cfg_subdiv == 3) ? 3 : cfg_subdiv + 1;
            if (!res_pin_n) begin
                if (m_mode != B_RSTH) nc = 8 << cfg_settle;
                nm = B_RSTH;
            end else if (m_mode == B_RSTH) begin
                if (m_cnt == 0) nm = B_ACT;
            end else if (run) begin
                if (sleep_req) begin
                    m_ret = (m_mode == B_SUB);
                    if (cfg_standby) nm = B_STBY;
                    else if (cfg_direct) begin
                        if (cfg_lowspeed) nm = B_SUB;
                        else if (m_mode == B_SUB) begin nm = B_SET; nc = 8 << cfg_settle; end
                    end else nm = cfg_lowspeed ? B_SSLP : B_SLP;
                end
            end else if (m_mode == B_SLP || m_mode == B_SSLP) begin
                if (hit) begin
                    nw = 1;
                    if ((m_mode == B_SLP) ? m_ret != 0 : cfg_lowspeed) nm = B_SUB;
                    else begin nm = B_SET; nc = 8 << cfg_settle; end
                end
            end else if (m_mode == B_SET) begin
                if (m_cnt == 1) nm = B_ACT;
            end
            m_mode = nm; m_cnt = nc; m_wake = nw;
        end
    end

    // compare every output on every cycle
    always @(negedge clk) begin : cmp
        string tag;
        int e_cpu, e_per, e_osc, e_sh;
        if (started && !done) begin
            case (m_mode)
                B_SSLP: tag = "R1";  B_SET: tag = "R4";  B_SLP: tag = "R8";
                B_STBY: tag = "R9";  B_RSTH: tag = "R10"; default: tag = "R7";
            endcase
            e_cpu = (m_mode == B_ACT || m_mode == B_SUB);
            e_per = e_cpu || (m_mode == B_SLP);
            e_osc = (m_mode == B_ACT || m_mode == B_SET || m_mode == B_RSTH ||
                     (m_mode == B_SLP && m_ret == 0));
            e_sh  = (m_mode == B_SUB || m_mode == B_SSLP || (m_mode == B_SLP && m_ret != 0)) ? m_shift : 0;
            chk({tag, " cpu_clk_en"}, cpu_clk_en, e_cpu);
            chk({tag, " per_clk_en"}, per_clk_en, e_per);
            chk({tag, " rtc_clk_en"}, rtc_clk_en, m_mode != B_RSTH);
            chk({tag, " osc_en"}, osc_en, e_osc);
            chk({tag, " int_rst"}, int_rst, m_mode == B_RSTH);
            chk("R5 clk_shift", clk_shift, e_sh);
            chk("R11 wake_pulse", wake_pulse, m_wake);
        end
    end

    task automatic req();
        sleep_req = 1; @(negedge clk); sleep_req = 0;
    endtask

    task automatic cfg(bit sb, bit dr, bit ls);
        cfg_standby = sb; cfg_direct = dr; cfg_lowspeed = ls;
    endtask

    task automatic summary();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog: got 1 expected 0");
        summary();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R10 reset holds internal reset", int_rst, 1);
        rst_n = 1;
        @(negedge clk);
        chk("R10 release to active after reset", cpu_clk_en, 1);

        cfg_subdiv = 2'b01; cfg(0, 1, 1); req();
        chk("R7 direct to subactive", cpu_clk_en, 1);
        chk("R5 divide by 4", clk_shift, 2);

        cfg(0, 0, 1); req();
        chk("R1 subsleep cpu off", cpu_clk_en, 0);
        chk("R1 subsleep rtc on", rtc_clk_en, 1);
        cfg_subdiv = 2'b00;
        irq_pend = 8'h04; irq_en = 8'h00;
        repeat (3) @(negedge clk);
        chk("R2 disabled source ignored", cpu_clk_en, 0);
        irq_en = 8'h04; irq_gmask = 1;
        repeat (3) @(negedge clk);
        chk("R2 global mask blocks", cpu_clk_en, 0);
        irq_gmask = 0; @(negedge clk); irq_pend = 0;
        chk("R3 wake into subactive", cpu_clk_en, 1);
        chk("R6 ratio restored", clk_shift, 2);
        chk("R11 wake strobe", wake_pulse, 1);
        @(negedge clk);
        chk("R11 strobe one cycle", wake_pulse, 0);

        cfg(0, 0, 0); req();
        chk("R8 sleep keeps peripherals", per_clk_en, 1);
        irq_pend = 8'h04; @(negedge clk); irq_pend = 0;
        chk("R8 sleep from subactive returns", cpu_clk_en, 1);
        chk("R6 ratio sampled at request", clk_shift, 1);

        cfg_subdiv = 2'b11; cfg(0, 1, 1); req();
        chk("R5 reserved select is divide by 8", clk_shift, 3);

        cfg(0, 0, 1); req();
        cfg_lowspeed = 0; cfg_settle = 0; irq_pend = 8'h04;
        n = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); irq_pend = 0;
            if (cpu_clk_en) break;
            n++;
        end
        chk("R4 settle code 0 is 8 cycles", n, 8);
        chk("R5 full speed shift", clk_shift, 0);

        cfg(0, 1, 0); req();
        chk("R7 direct in active no change", cpu_clk_en, 1);

        cfg(0, 1, 1); req();
        cfg_lowspeed = 0; cfg_settle = 1; req();
        n = 0;
        for (int i = 0; i < 3000; i++) begin
            if (cpu_clk_en) break;
            n++; @(negedge clk);
        end
        chk("R4 settle code 1 is 16 cycles", n, 16);

        cfg(1, 0, 0); req();
        chk("R9 standby oscillator off", osc_en, 0);
        irq_pend = 8'h01; irq_en = 8'h01;
        repeat (5) @(negedge clk);
        chk("R9 interrupts ignored", cpu_clk_en, 0);
        irq_pend = 0; cfg_settle = 2; res_pin_n = 0;
        n = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (i == 2) res_pin_n = 1;
            if (!int_rst) break;
            n++;
        end
        chk("R10 hold lasts count plus one", n, 33);

        cfg(0, 0, 0); cfg_settle = 0; req();
        chk("R8 sleep from active keeps oscillator", osc_en, 1);
        irq_pend = 8'h01; @(negedge clk); irq_pend = 0;
        chk("R8 wake goes to settle", cpu_clk_en, 0);
        chk("R11 wake strobe from sleep", wake_pulse, 1);
        repeat (8) @(negedge clk);
        chk("R4 active after settle", cpu_clk_en, 1);

        summary();
    end
endmodule